// File: doc/BRIEF.md
# Rear Lamp Blink and Brake Controller

This block produces the power enables for the two rear lamps of a car. It receives four level requests from the cabin: left turn, right turn, hazard flasher and brake. From the system clock it derives its own one-hertz blink phase with a counter whose length is set by the `CLK_HZ` parameter. Each side then resolves its own requests by a fixed priority and drives a steady or blinking enable. A turn request on a side beats brake on that side. Brake beats the hazard flasher. Both sides blink on the same shared phase.

The requests are asynchronous to the clock and pass through a two-flop synchroniser. The lamp enables come straight from flops, so they never carry combinational glitches. All pins are plain level signals. There is no data stream and no handshake.

Top module: `rear_lamp_ctrl`

## Requirements
- R1: After reset the blink phase starts in its off half. It then toggles every CLK_HZ/2 clock cycles, so a blinking lamp is on for CLK_HZ/2 cycles in each period of CLK_HZ cycles.
- R2: A left-turn request alone makes the left lamp blink with the phase, and the right lamp stays off.
- R3: A right-turn request alone makes the right lamp blink with the phase, and the left lamp stays off.
- R4: A hazard request alone makes both lamps blink together, on the same phase.
- R5: A brake request alone turns both lamps on steadily.
- R6: With brake and hazard both active and no turn request, both lamps stay on steadily.
- R7: A turn request together with brake makes its own side blink and leaves the other side steadily on.
- R8: Both turn requests together make both lamps blink. Each side follows its own request, with or without brake and hazard.
- R9: With no request active, both lamps are off.
- R10: A change on a request input reaches the lamp enable after three rising clock edges: two synchroniser flops and the output flop.
- R11: While the synchronous active-high reset is high, both enables are low after every clock edge. The synchronisers and the divider are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ cycles per second |
| rst | input | 1 | Synchronous reset, active high |
| turn_left_req | input | 1 | Left turn request, asynchronous level |
| turn_right_req | input | 1 | Right turn request, asynchronous level |
| hazard_req | input | 1 | Hazard flasher request, asynchronous level |
| brake_req | input | 1 | Brake request, asynchronous level |
| lamp_left_en | output | 1 | Left rear lamp power enable, registered |
| lamp_right_en | output | 1 | Right rear lamp power enable, registered |

## Verification
Three functions can land on one lamp in the same cycle: the steady brake drive, the turn blink and the hazard blink. Where they collide, the priority and the shared phase decide the result. The bench applies every mix of turn, hazard and brake and holds each mix for a full blink period. In each cycle it compares both lamps against the phase it derives from its own count of cycles since reset. A turn combined with brake must blink on its own side and stay steady on the other. Brake combined with hazard must stay steady with no off half.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

  localparam int NUM_SIDES = 2;

  typedef enum int {
    SIDE_LEFT  = 0,
    SIDE_RIGHT = 1
  } side_e;

  // Synchronised request bundle; order only matters inside this block.
  typedef struct packed {
    logic turn_l;
    logic turn_r;
    logic hazard;
    logic brake;
  } req_t;

  localparam int REQ_W = $bits(req_t);

endpackage

// File: rtl/rlc_sync.sv
module rlc_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= async_in;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

  // R10: the synchroniser output equals the first stage delayed by its remaining stages
  a_r10_sync_shift: assert property (@(posedge clk) disable iff (rst)
    (STAGES == 2) |=> sync_out == $past(stage_q[0]));

endmodule

// File: rtl/rlc_blink_gen.sv
module rlc_blink_gen #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic phase
);

  localparam int HALF = CLK_HZ / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign phase = phase_q;

  // R1: the phase flips exactly when a half period ends
  a_r1_phase_flip: assert property (@(posedge clk) disable iff (rst)
    wrap |=> phase != $past(phase));

  // R1: the phase holds inside a half period
  a_r1_phase_hold: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(phase));

  // R1: the counter never leaves its half period range
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/rlc_side.sv
module rlc_side (
  input  logic clk,
  input  logic rst,
  input  logic turn,
  input  logic brake,
  input  logic hazard,
  input  logic phase,
  output logic lamp_en
);

  logic drive_d;
  logic lamp_q;

  // Turn blinks, brake is steady only without a turn, hazard blinks.
  always_comb begin
    drive_d = 1'b0;
    if (turn && phase)   drive_d = 1'b1;
    if (!turn && brake)  drive_d = 1'b1;
    if (hazard && phase) drive_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) lamp_q <= 1'b0;
    else     lamp_q <= drive_d;
  end

  assign lamp_en = lamp_q;

  // R5, R6: brake without a turn holds the lamp on whatever the phase
  a_r6_brake_steady: assert property (@(posedge clk) disable iff (rst)
    (brake && !turn) |=> lamp_en);

  // R9: no request on this side keeps the lamp dark
  a_r9_idle_off: assert property (@(posedge clk) disable iff (rst)
    (!turn && !brake && !hazard) |=> !lamp_en);

  // R7: a turn request follows the phase even when braking
  a_r7_turn_blinks: assert property (@(posedge clk) disable iff (rst)
    (turn && !phase && !hazard) |=> !lamp_en);

  // R4: hazard with the phase high lights the lamp
  a_r4_hazard_on: assert property (@(posedge clk) disable iff (rst)
    (hazard && phase) |=> lamp_en);

endmodule

// File: rtl/rear_lamp_ctrl.sv
module rear_lamp_ctrl #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic turn_left_req,
  input  logic turn_right_req,
  input  logic hazard_req,
  input  logic brake_req,
  output logic lamp_left_en,
  output logic lamp_right_en
);

  import rlc_pkg::*;

  req_t raw_req;
  req_t req_s;
  logic phase;
  logic [NUM_SIDES-1:0] side_turn;
  logic [NUM_SIDES-1:0] side_lamp;

  assign raw_req = '{turn_l: turn_left_req, turn_r: turn_right_req,
                     hazard: hazard_req, brake: brake_req};

  rlc_sync #(
    .WIDTH  (REQ_W),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (raw_req),
    .sync_out (req_s)
  );

  rlc_blink_gen #(
    .CLK_HZ (CLK_HZ)
  ) i_blink (
    .clk   (clk),
    .rst   (rst),
    .phase (phase)
  );

  assign side_turn[SIDE_LEFT]  = req_s.turn_l;
  assign side_turn[SIDE_RIGHT] = req_s.turn_r;

  for (genvar i = 0; i < NUM_SIDES; i++) begin : g_side
    rlc_side i_side (
      .clk     (clk),
      .rst     (rst),
      .turn    (side_turn[i]),
      .brake   (req_s.brake),
      .hazard  (req_s.hazard),
      .phase   (phase),
      .lamp_en (side_lamp[i])
    );
  end

  assign lamp_left_en  = side_lamp[SIDE_LEFT];
  assign lamp_right_en = side_lamp[SIDE_RIGHT];

  // R8: with both turns and no other request the two lamps blink in step
  a_r8_both_turns_in_step: assert property (@(posedge clk) disable iff (rst)
    (req_s.turn_l && req_s.turn_r) |=> lamp_left_en == lamp_right_en);

  // R4: hazard alone keeps both lamps in step
  a_r4_hazard_in_step: assert property (@(posedge clk) disable iff (rst)
    (req_s.hazard && !req_s.turn_l && !req_s.turn_r) |=> lamp_left_en == lamp_right_en);

endmodule

// File: tb/test_rear_lamp_ctrl.sv
module test_rear_lamp_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int TB_HZ      = 8;
  localparam int HALF       = TB_HZ / 2;
  localparam int NVEC       = 12;

  // Vector: {turn_left, turn_right, hazard, brake, requirement number}
  // R9 idle, R2 left, R3 right, R4 hazard, R5 brake, R6 brake+hazard,
  // R7 turn+brake both sides, R8 both turns (plain, with brake, with hazard),
  // R2 left turn with hazard.
  localparam logic [7:0] VEC [NVEC] = '{
    {4'b0000, 4'd9}, {4'b1000, 4'd2}, {4'b0100, 4'd3}, {4'b0010, 4'd4},
    {4'b0001, 4'd5}, {4'b0011, 4'd6}, {4'b1001, 4'd7}, {4'b0101, 4'd7},
    {4'b1100, 4'd8}, {4'b1101, 4'd8}, {4'b1110, 4'd8}, {4'b1010, 4'd2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tl = 1'b0, tr = 1'b0, hz = 1'b0, br = 1'b0;
  logic lamp_l, lamp_r;
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  rear_lamp_ctrl #(.CLK_HZ(TB_HZ)) i_rear_lamp_ctrl (
    .clk            (clk),
    .rst            (rst),
    .turn_left_req  (tl),
    .turn_right_req (tr),
    .hazard_req     (hz),
    .brake_req      (br),
    .lamp_left_en   (lamp_l),
    .lamp_right_en  (lamp_r)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Edges since reset release; the phase after edge m is (m/HALF)%2.
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  function automatic logic side_exp(logic turn, logic brake, logic hazard, logic ph);
    return (turn & ph) | (~turn & brake) | (hazard & ph);
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ph;
    int rise_a, rise_b, high_cnt;
    // R11: reset state
    tick(3);
    check("R11", lamp_l, 1'b0, "left in reset");
    check("R11", lamp_r, 1'b0, "right in reset");
    rst = 1'b0;

    // Vector table walk: hold each mix for three edges, then a full period.
    for (int v = 0; v < NVEC; v++) begin
      {tl, tr, hz, br} = VEC[v][7:4];
      tick(3);
      for (int k = 0; k < 2*HALF; k++) begin
        ph = 1'(((cyc - 1) / HALF) % 2);
        check($sformatf("R%0d", VEC[v][3:0]), lamp_l, side_exp(tl, br, hz, ph), "left");
        check($sformatf("R%0d", VEC[v][3:0]), lamp_r, side_exp(tr, br, hz, ph), "right");
        tick(1);
      end
    end

    // R10: latency of three edges from idle to brake
    {tl, tr, hz, br} = 4'b0000;
    tick(4);
    br = 1'b1;
    tick(1);
    check("R10", lamp_l, 1'b0, "after edge 1");
    tick(1);
    check("R10", lamp_l, 1'b0, "after edge 2");
    tick(1);
    check("R10", lamp_l, 1'b1, "after edge 3");
    check("R10", lamp_r, 1'b1, "right after edge 3");

    // R11: reset while braking clears the lamps at once
    rst = 1'b1;
    tick(1);
    check("R11", lamp_l, 1'b0, "left after reset edge");
    check("R11", lamp_r, 1'b0, "right after reset edge");

    // R1/R11: phase starts in its off half after release, hazard held
    br = 1'b0;
    hz = 1'b1;
    tick(2);
    rst = 1'b0;
    for (int e = 1; e <= HALF; e++) begin
      tick(1);
      check("R1", lamp_l, 1'b0, $sformatf("off half edge %0d", e));
    end
    tick(1);
    check("R1", lamp_l, 1'b1, "first on edge");

    // R1: period and high width measured on the left lamp
    rise_a = -1;
    rise_b = -1;
    high_cnt = 0;
    for (int k = 0; k < 6*HALF; k++) begin
      logic prev;
      prev = lamp_l;
      tick(1);
      if (lamp_l && !prev) begin
        if (rise_a < 0) rise_a = cyc;
        else if (rise_b < 0) rise_b = cyc;
      end
      if (rise_a >= 0 && rise_b < 0 && lamp_l) high_cnt++;
    end
    check("R1", 1'(rise_b - rise_a == 2*HALF), 1'b1, "period of CLK_HZ cycles");
    check("R1", 1'(high_cnt == HALF), 1'b1, "on time of CLK_HZ/2 cycles");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule